// File: doc/BRIEF.md
# Stereo Serial Audio Master Transmitter

This block drives a three-wire stereo audio link as the clock master. It divides one of two reference timebases down to a bit clock, produces the word-select (channel) clock, and shifts out one left and one right PCM word per frame. The reference timebases arrive as single-cycle tick strobes in the block's own clock domain, one strobe per reference period, so the block has a single clock and its outputs change only on clock edges.

Samples are offered as a left/right pair with a valid/ready handshake. The block accepts a pair only at the start of a frame. If no pair is offered there, it sends the previous pair again. Static control inputs select the tick source, the half-period divisor, the data alignment (standard, left-aligned, right-aligned), a channel slot of 16 or 32 bit clocks, the sample length, and the output polarity of both clocks.

Top module: `i2s_tx_master`

## Requirements
- R1: The raw bit clock toggles only on a tick of the selected reference and holds each level for max(div_half,1) such ticks. A div_half of 0 acts as 1, so the bit clock never exceeds half the reference rate.
- R2: ref_sel=0 selects ref_tick_a and ref_sel=1 selects ref_tick_b as the divider's tick source.
- R3: slot32=0 gives 16 bit clocks per channel and slot32=1 gives 32. A frame is the left slot followed by the right slot. The raw channel clock is 0 during the left slot and 1 during the right slot.
- R4: fmt=0 (standard) puts the MSB on the second bit clock of a slot. When the sample length equals the slot, the LSB lands on the first bit clock of the following slot. Otherwise that first bit is 0.
- R5: fmt=1 (left-aligned) puts the MSB on the first bit clock of a slot. fmt=3 behaves the same way.
- R6: fmt=2 (right-aligned) puts the LSB on the last bit clock of a slot.
- R7: len_sel selects the sample length: 0=16, 1=20, 2=24, 3=32 bits, taken from the low bits of each word. A length larger than the slot is cut to the slot, keeping the low bits. Slot positions that carry no sample bit output 0.
- R8: Serial data and the channel clock change only on the edge where the raw bit clock falls.
- R9: bclk_o equals the raw bit clock XOR bclk_inv. lrclk_o equals the raw channel clock XOR lr_inv.
- R10: s_ready is high for exactly one cycle: the cycle whose rising edge starts a new frame. A pair presented with s_valid in that cycle is sent in that frame. Without it, the held pair is sent again. A pair held outside that cycle has no effect.
- R11: While reset is held, the raw bit clock is 0, the raw channel clock is 1, sdata_o is 0 and s_ready is 0 (with no ticks pending).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_a | input | 1 | Tick strobe of reference A |
| ref_tick_b | input | 1 | Tick strobe of reference B |
| ref_sel | input | 1 | Reference select (0=A, 1=B) |
| div_half | input | DIV_W | Bit clock half period in reference ticks |
| fmt | input | 2 | Alignment: 0 standard, 1 left, 2 right, 3 left |
| slot32 | input | 1 | Slot size: 0=16, 1=32 bit clocks |
| len_sel | input | 2 | Sample length: 16/20/24/32 |
| bclk_inv | input | 1 | Invert the bit clock output |
| lr_inv | input | 1 | Invert the channel clock output |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Sample pair accepted this cycle |
| s_left | input | SAMPLE_W | Left sample, right-justified in the word |
| s_right | input | SAMPLE_W | Right sample, right-justified in the word |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Channel clock |
| sdata_o | output | 1 | Serial data |

## Verification
In standard alignment with full-slot samples, the frame-start edge does two things at once. It accepts a new pair, and it emits the LSB of the old right word as the first bit of the new left slot. To provoke this, two distinct 16-bit pairs are sent back to back in standard mode, and the frame that carries the second pair is captured. The check passes if that frame's first bit is the LSB of the first pair's right word and every other bit comes from the second pair. The same captures also check the channel-clock level at every bit and the bit-clock period against the selected divisor.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    typedef enum logic [1:0] {
        FMT_STD   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_ALT   = 2'd3
    } fmt_e;

    localparam int POS_W = 6;

    function automatic int len_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/i2s_tx_clkdiv.sv
module i2s_tx_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick_a,
    input  logic             ref_tick_b,
    input  logic             ref_sel,
    input  logic [DIV_W-1:0] div_half,
    output logic             bclk_raw,
    output logic             fall_stb
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bclk;
    } div_st_t;

    div_st_t st_d, st_q;
    logic             tick;
    logic [DIV_W-1:0] half_m1;
    logic             wrap;

    always_comb begin
        st_d     = st_q;
        tick     = ref_sel ? ref_tick_b : ref_tick_a;
        half_m1  = (div_half == '0) ? '0 : div_half - 1'b1;
        wrap     = tick && (st_q.cnt >= half_m1);
        fall_stb = wrap && st_q.bclk;
        if (tick) begin
            if (wrap) begin
                st_d.cnt  = '0;
                st_d.bclk = ~st_q.bclk;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_raw = st_q.bclk;

    // R1: a level change needs a tick from the selected reference
    assert_toggle_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.bclk) |-> $past(ref_sel ? ref_tick_b : ref_tick_a));

endmodule

// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer
    import i2s_tx_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_stb,
    input  logic [1:0]          fmt,
    input  logic                slot32,
    input  logic [1:0]          len_sel,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                sdata,
    output logic                lr
);

    localparam int IDX_W = $clog2(SAMPLE_W);

    typedef struct packed {
        logic [POS_W-1:0]    pos;
        logic                lr;
        logic                sd;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic                frame_start, take, rch, bit_n;
    logic [POS_W-1:0]    npos, last_pos;
    logic [SAMPLE_W-1:0] wl, wr, word;
    int                  slot_i, len_i, k_i;

    always_comb begin
        st_d     = st_q;
        slot_i   = slot32 ? 32 : 16;
        len_i    = len_bits(len_sel);
        if (len_i > slot_i)   len_i = slot_i;
        if (len_i > SAMPLE_W) len_i = SAMPLE_W;
        last_pos    = slot32 ? 6'd63 : 6'd31;
        frame_start = fall_stb && (st_q.pos >= last_pos);
        npos        = frame_start ? '0 : st_q.pos + 1'b1;
        take        = frame_start && s_valid;
        wl          = take ? s_left  : st_q.left;
        wr          = take ? s_right : st_q.right;
        rch         = slot32 ? npos[5] : npos[4];
        k_i         = slot32 ? int'(npos[4:0]) : int'(npos[3:0]);
        word        = rch ? wr : wl;
        bit_n       = 1'b0;
        case (fmt_e'(fmt))
            FMT_STD: begin
                if (k_i == 0) begin
                    if (len_i == slot_i) bit_n = rch ? wl[0] : st_q.right[0];
                end else if (k_i <= len_i) begin
                    bit_n = word[IDX_W'(len_i - k_i)];
                end
            end
            FMT_RIGHT: begin
                if (k_i >= slot_i - len_i) bit_n = word[IDX_W'(slot_i - 1 - k_i)];
            end
            default: begin
                if (k_i < len_i) bit_n = word[IDX_W'(len_i - 1 - k_i)];
            end
        endcase
        if (fall_stb) begin
            st_d.pos   = npos;
            st_d.lr    = rch;
            st_d.sd    = bit_n;
            st_d.left  = wl;
            st_d.right = wr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= '1;
            st_q.lr  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign s_ready = frame_start;
    assign sdata   = st_q.sd;
    assign lr      = st_q.lr;

    // R3: bit position advances only on a bit clock fall
    assert_pos_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.pos) |-> $past(fall_stb));

    // R10: held pair changes only through an accepted handshake
    assert_hold_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.left) || !$stable(st_q.right)) |-> $past(s_valid && s_ready));

endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master #(
    parameter int DIV_W    = 8,
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_tick_a,
    input  logic                ref_tick_b,
    input  logic                ref_sel,
    input  logic [DIV_W-1:0]    div_half,
    input  logic [1:0]          fmt,
    input  logic                slot32,
    input  logic [1:0]          len_sel,
    input  logic                bclk_inv,
    input  logic                lr_inv,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                bclk_o,
    output logic                lrclk_o,
    output logic                sdata_o
);

    logic bclk_w, fall_w, lr_w, sd_w;

    i2s_tx_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_a (ref_tick_a),
        .ref_tick_b (ref_tick_b),
        .ref_sel    (ref_sel),
        .div_half   (div_half),
        .bclk_raw   (bclk_w),
        .fall_stb   (fall_w)
    );

    i2s_tx_framer #(.SAMPLE_W(SAMPLE_W)) i_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_stb (fall_w),
        .fmt      (fmt),
        .slot32   (slot32),
        .len_sel  (len_sel),
        .s_valid  (s_valid),
        .s_ready  (s_ready),
        .s_left   (s_left),
        .s_right  (s_right),
        .sdata    (sd_w),
        .lr       (lr_w)
    );

    assign bclk_o  = bclk_w ^ bclk_inv;
    assign lrclk_o = lr_w ^ lr_inv;
    assign sdata_o = sd_w;

    // R8: data and channel clock move together with a falling raw bit clock
    assert_data_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sd_w) || !$stable(lr_w)) |-> $fell(bclk_w));

endmodule

// File: tb/test_i2s_tx_master.sv
module test_i2s_tx_master;

    typedef struct packed {
        logic [1:0]  fmt;
        logic        slot32;
        logic [1:0]  lsel;
        logic [7:0]  div;
        logic        rsel;
        logic        binv;
        logic        linv;
        logic [31:0] l;
        logic [31:0] r;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 2'd3, 8'd1, 1'b0, 1'b0, 1'b0, 32'hA5C30F81, 32'h12345679},
        '{2'd1, 1'b0, 2'd0, 8'd2, 1'b0, 1'b1, 1'b0, 32'h0000BEEF, 32'h00001357},
        '{2'd2, 1'b1, 2'd2, 8'd1, 1'b1, 1'b0, 1'b1, 32'h00F00F33, 32'h00ABCDEF},
        '{2'd0, 1'b0, 2'd2, 8'd1, 1'b0, 1'b0, 1'b0, 32'h00FF8421, 32'h0012F00D},
        '{2'd1, 1'b1, 2'd1, 8'd3, 1'b0, 1'b1, 1'b1, 32'h000F1234, 32'h000ABCDE},
        '{2'd0, 1'b1, 2'd0, 8'd1, 1'b1, 1'b0, 1'b0, 32'h0000C001, 32'h00007FFE},
        '{2'd3, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 1'b0, 32'h0000A5F1, 32'h00003C96}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick_a, ref_tick_b, ref_sel;
    logic [7:0]  div_half;
    logic [1:0]  fmt, len_sel;
    logic        slot32, bclk_inv, lr_inv, s_valid, s_ready;
    logic [31:0] s_left, s_right;
    logic        bclk_o, lrclk_o, sdata_o;

    int total = 0;
    int bad = 0;
    longint cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2s_tx_master i_i2s_tx_master (
        .clk(clk), .rst_n(rst_n), .ref_tick_a(ref_tick_a), .ref_tick_b(ref_tick_b),
        .ref_sel(ref_sel), .div_half(div_half), .fmt(fmt), .slot32(slot32),
        .len_sel(len_sel), .bclk_inv(bclk_inv), .lr_inv(lr_inv), .s_valid(s_valid),
        .s_ready(s_ready), .s_left(s_left), .s_right(s_right), .bclk_o(bclk_o),
        .lrclk_o(lrclk_o), .sdata_o(sdata_o)
    );

    // Reference ticks: A every cycle, B every second cycle
    initial begin
        ref_tick_a = 1'b1;
        ref_tick_b = 1'b0;
        forever begin
            @(negedge clk);
            ref_tick_b = ~ref_tick_b;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_bit(input logic [1:0] f, input logic s32, input logic [1:0] ls,
                                   input logic [31:0] l, input logic [31:0] r,
                                   input logic [31:0] prev_r, input int p);
        int slot, len, k;
        logic [31:0] w;
        slot = s32 ? 32 : 16;
        case (ls) 2'd0: len = 16; 2'd1: len = 20; 2'd2: len = 24; default: len = 32; endcase
        if (len > slot) len = slot;
        k = p % slot;
        w = (p >= slot) ? r : l;
        if (f == 2'd0) begin
            if (k == 0) return (len == slot) ? ((p >= slot) ? l[0] : prev_r[0]) : 1'b0;
            if (k <= len) return w[len - k];
            return 1'b0;
        end else if (f == 2'd2) begin
            if (k >= slot - len) return w[slot - 1 - k];
            return 1'b0;
        end
        if (k < len) return w[len - 1 - k];
        return 1'b0;
    endfunction

    task automatic set_cfg(input vec_t v);
        @(negedge clk);
        rst_n    = 1'b0;
        fmt      = v.fmt;  slot32  = v.slot32; len_sel = v.lsel;
        div_half = v.div;  ref_sel = v.rsel;
        bclk_inv = v.binv; lr_inv  = v.linv;
        s_valid  = 1'b0;   s_left  = '0;       s_right = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_pair(input logic [31:0] l, input logic [31:0] r);
        s_left = l; s_right = r; s_valid = 1'b1;
        forever begin
            #1;
            if (s_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        #1;
        check(s_ready == 1'b0, "R10 ready pulse", s_ready, 0);
    endtask

    task automatic capture(input logic s32, input logic bi, input logic li,
                           output logic [63:0] bits, output logic [63:0] lrs, output longint per);
        int n, pos;
        logic prev_raw, raw, l, last_lr;
        longint t0;
        n = s32 ? 64 : 32;
        pos = -1; last_lr = 1'b0; bits = '0; lrs = '0; per = 0; t0 = 0;
        @(negedge clk);
        prev_raw = bclk_o ^ bi;
        forever begin
            @(negedge clk);
            raw = bclk_o ^ bi;
            if (!prev_raw && raw) begin
                l = lrclk_o ^ li;
                if (pos < 0 && l == 1'b0 && last_lr == 1'b1) pos = 0;
                else if (pos >= 0) pos++;
                last_lr = l;
                if (pos >= 0) begin
                    bits[pos] = sdata_o;
                    lrs[pos]  = l;
                    if (pos == 0) t0 = cyc;
                    if (pos == 1) per = cyc - t0;
                    if (pos == n - 1) break;
                end
            end
            prev_raw = raw;
        end
    endtask

    task automatic judge(input vec_t v, input logic [31:0] prev_r, input logic [63:0] bits,
                         input logic [63:0] lrs, input string tag);
        int n, slot;
        logic [63:0] eb, el;
        slot = v.slot32 ? 32 : 16;
        n = 2 * slot;
        eb = '0; el = '0;
        for (int p = 0; p < n; p++) begin
            eb[p] = exp_bit(v.fmt, v.slot32, v.lsel, v.l, v.r, prev_r, p);
            el[p] = (p >= slot);
        end
        check(bits == eb, tag, bits, eb);
        check(lrs == el, "R3 R9 channel level per bit", lrs, el);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] bits, lrs;
        longint per, eper;
        int half;
        vec_t d;

        // R11 reset state, polarity applied (R9)
        d = VEC[1];
        @(negedge clk);
        fmt = d.fmt; slot32 = d.slot32; len_sel = d.lsel; div_half = d.div;
        ref_sel = d.rsel; bclk_inv = 1'b1; lr_inv = 1'b0;
        s_valid = 1'b0; s_left = '0; s_right = '0;
        repeat (3) @(negedge clk);
        check(bclk_o == 1'b1, "R11 reset bclk (inverted)", bclk_o, 1);
        check(lrclk_o == 1'b1, "R11 reset lrclk", lrclk_o, 1);
        check(sdata_o == 1'b0, "R11 reset sdata", sdata_o, 0);
        check(s_ready == 1'b0, "R11 reset ready", s_ready, 0);

        // Vector table: each pair sent once, the repeated frame is judged
        for (int i = 0; i < NV; i++) begin
            set_cfg(VEC[i]);
            send_pair(VEC[i].l, VEC[i].r);
            capture(VEC[i].slot32, VEC[i].binv, VEC[i].linv, bits, lrs, per);
            judge(VEC[i], VEC[i].r, bits, lrs, "R4 R5 R6 R7 R10 frame bits");
            half = (VEC[i].div == 0) ? 1 : int'(VEC[i].div);
            eper = 2 * half * (VEC[i].rsel ? 2 : 1);
            check(per == eper, "R1 R2 bclk period", per, eper);
        end

        // Back-to-back distinct pairs: new pair accepted while old right LSB spills (R4, R10)
        d = '{2'd0, 1'b0, 2'd0, 8'd1, 1'b0, 1'b0, 1'b0, 32'h0000F0F0, 32'h0000AAAB};
        set_cfg(d);
        send_pair(d.l, d.r);
        fork
            capture(1'b0, 1'b0, 1'b0, bits, lrs, per);
            send_pair(32'h00001234, 32'h00008765);
        join
        begin
            vec_t d2;
            d2 = d; d2.l = 32'h00001234; d2.r = 32'h00008765;
            judge(d2, d.r, bits, lrs, "R4 R10 spill of previous right LSB");
            check(bits[0] == 1'b1, "R4 first bit is old right LSB", bits[0], 1);
        end

        // Offered pair outside the boundary has no effect until the next boundary (R10)
        d = VEC[1];
        set_cfg(d);
        send_pair(d.l, d.r);
        repeat (5) @(negedge clk);
        s_left = 32'h0000FFFF; s_right = 32'h0000FFFF;
        capture(d.slot32, d.binv, d.linv, bits, lrs, per);
        judge(d, d.r, bits, lrs, "R10 held pair unchanged without ready");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule